// File: doc/BRIEF.md
# Encoder-Stepped Chromatic Speed Selector

This block converts a debounced two-phase rotary encoder into a 16-bit playback-speed word that moves in equal-tempered semitone steps. A speed word of 0x0100 means unity speed. Each semitone multiplies the speed by the twelfth root of two. The selectable range is one octave below unity to one octave above it.

The encoder phases first pass through a two-flop synchronizer. The block then looks at them only once every 64 audio sample strobes. A small state machine turns a falling edge on phase A into exactly one step. Phase B at that moment gives the direction. The step moves a clamped semitone index, and a constant table maps that index to the registered speed word.

State machine:
- States:
  - `SCAN_ARMED`: waiting for phase A to be seen low.
  - `SCAN_LATCHED`: an edge has been taken, and the block waits for phase A to be seen high again.
- Transitions (both happen only on a scan tick):
  - `take_edge`, from ARMED to LATCHED, when phase A is low. This issues one step.
  - `rearm`, from LATCHED to ARMED, when phase A is high.

Top module: `chroma_rate_sel`

## Requirements
- R1: After reset the semitone index is 12, the state is `SCAN_ARMED`, and `rate_word` is 0x0100.
- R2: The synchronized encoder phases are evaluated only on every 64th `smp_stb` pulse. A new phase value that is present for fewer than 64 strobes causes no step.
- R3: In `SCAN_ARMED`, a scan that sees phase A low issues one step and enters `SCAN_LATCHED`. A scan that sees phase A high issues no step.
- R4: In `SCAN_LATCHED`, scans issue no step, whatever the phases are. A scan that sees phase A high returns the machine to `SCAN_ARMED`.
- R5: At a step, phase B high decrements the index (left turn) and phase B low increments it (right turn).
- R6: The index stays in the range 0 to 24. A decrement at 0 or an increment at 24 leaves it unchanged.
- R7: `rate_word` for index i is round(128 * 2^(i/12)). The values from index 0 upward are:
  - 0x0080, 0x0088, 0x0090, 0x0098, 0x00A1, 0x00AB, 0x00B5
  - 0x00C0, 0x00CB, 0x00D7, 0x00E4, 0x00F2
  - 0x0100, 0x010F, 0x011F, 0x0130, 0x0143, 0x0156, 0x016A
  - 0x0180, 0x0196, 0x01AF, 0x01C8, 0x01E3, 0x0200
- R8: `rate_word` is registered. It changes one clock after the index changes, and it is stable at all other times.
- R9: `enc_a` and `enc_b` pass through two flops before the scan logic. A phase change applied in the same cycle as the 64th strobe is not seen by that scan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_stb | input | 1 | Audio sample strobe, one cycle per sample |
| enc_a | input | 1 | Encoder phase A (debounced, asynchronous) |
| enc_b | input | 1 | Encoder phase B (debounced, asynchronous) |
| rate_word | output | 16 | Playback speed word, 0x0100 = unity |

## Verification
A phase change reaches the scan logic two clocks after it is applied. It is acted on at the clock edge that carries the 64th strobe: the index changes at that edge, and `rate_word` changes at the following edge. The bench therefore settles the pins for several cycles before it issues strobes. After the strobe that makes the tick, it samples `rate_word` at the next falling clock edge and expects the old value. It samples again one edge later and expects the new value. Expected words come from round(128 * 2^(i/12)) on the bench's own index model, which sweeps the whole range and both clamps in both directions.

// File: rtl/chroma_pkg.sv
package chroma_pkg;
    localparam int NSTEP = 25;
    localparam int HOME  = 12;
    localparam int IDX_W = $clog2(NSTEP);
    localparam int RATE_W = 16;

    typedef enum logic {
        SCAN_ARMED   = 1'b0,
        SCAN_LATCHED = 1'b1
    } scan_state_t;

    function automatic logic [RATE_W-1:0] semitone_rate(input logic [IDX_W-1:0] i);
        logic [RATE_W-1:0] r;
        unique case (i)
            5'd0:  r = 16'h0080;
            5'd1:  r = 16'h0088;
            5'd2:  r = 16'h0090;
            5'd3:  r = 16'h0098;
            5'd4:  r = 16'h00A1;
            5'd5:  r = 16'h00AB;
            5'd6:  r = 16'h00B5;
            5'd7:  r = 16'h00C0;
            5'd8:  r = 16'h00CB;
            5'd9:  r = 16'h00D7;
            5'd10: r = 16'h00E4;
            5'd11: r = 16'h00F2;
            5'd12: r = 16'h0100;
            5'd13: r = 16'h010F;
            5'd14: r = 16'h011F;
            5'd15: r = 16'h0130;
            5'd16: r = 16'h0143;
            5'd17: r = 16'h0156;
            5'd18: r = 16'h016A;
            5'd19: r = 16'h0180;
            5'd20: r = 16'h0196;
            5'd21: r = 16'h01AF;
            5'd22: r = 16'h01C8;
            5'd23: r = 16'h01E3;
            5'd24: r = 16'h0200;
            default: r = 16'h0100;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/phase_sync.sv
module phase_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    stage_q[s] <= '1;
                else if (s == 0)
                    stage_q[s] <= din;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/scan_divider.sv
module scan_divider #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (stb)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign tick = stb && (cnt_q == LAST);
endmodule

// File: rtl/enc_step_fsm.sv
module enc_step_fsm
    import chroma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic a_s,
    input  logic b_s,
    output logic step_up,
    output logic step_dn
);
    scan_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= SCAN_ARMED;
        else
            st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SCAN_ARMED:   if (tick && !a_s) st_d = SCAN_LATCHED;   // take_edge
            SCAN_LATCHED: if (tick &&  a_s) st_d = SCAN_ARMED;     // rearm
            default:      st_d = SCAN_ARMED;
        endcase
    end

    always_comb begin
        step_up = 1'b0;
        step_dn = 1'b0;
        unique case (st_q)
            SCAN_ARMED: begin
                step_up = tick && !a_s && !b_s;
                step_dn = tick && !a_s &&  b_s;
            end
            SCAN_LATCHED: ;
            default: ;
        endcase
    end

    // R2
    state_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q));
    // R4
    latched_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SCAN_LATCHED) |-> !(step_up || step_dn));
    // R5
    one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_up, step_dn}));
endmodule

// File: rtl/semitone_index.sv
module semitone_index
    import chroma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_up,
    input  logic             step_dn,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] TOP  = IDX_W'(NSTEP - 1);
    localparam logic [IDX_W-1:0] INIT = IDX_W'(HOME);

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx_q <= INIT;
        else if (step_up && idx_q != TOP)
            idx_q <= idx_q + 1'b1;
        else if (step_dn && idx_q != '0)
            idx_q <= idx_q - 1'b1;
    end

    assign idx = idx_q;

    // R6
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= TOP);
    // R5
    up_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && idx_q < TOP) |=> (idx_q == $past(idx_q) + 1'b1));
    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up || step_dn) |=> $stable(idx_q));
endmodule

// File: rtl/chroma_rate_sel.sv
module chroma_rate_sel
    import chroma_pkg::*;
#(
    parameter int SCAN_DIV = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        smp_stb,
    input  logic        enc_a,
    input  logic        enc_b,
    output logic [15:0] rate_word
);
    logic [1:0]       ph_s;
    logic             tick;
    logic             step_up, step_dn;
    logic [IDX_W-1:0] idx;
    logic [RATE_W-1:0] rate_q;

    // R9: two-flop synchronizer on both phases
    phase_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({enc_b, enc_a}), .dout(ph_s));

    scan_divider #(.DIV(SCAN_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .stb(smp_stb), .tick(tick));

    enc_step_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .a_s(ph_s[0]), .b_s(ph_s[1]),
        .step_up(step_up), .step_dn(step_dn));

    semitone_index u_idx (
        .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn), .idx(idx));

    // R7 R8: registered table lookup
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rate_q <= 16'h0100;
        else
            rate_q <= semitone_rate(idx);
    end

    assign rate_word = rate_q;

    // R8
    rate_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == $past(idx)) |=> $stable(rate_q));
endmodule

// File: tb/sim_chroma_rate_sel.sv
module sim_chroma_rate_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_stb = 1'b0;
    logic        enc_a = 1'b1;
    logic        enc_b = 1'b1;
    logic [15:0] rate_word;

    int checks = 0;
    int failures = 0;
    int m_idx = 12;
    bit m_latched = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    chroma_rate_sel u0 (.clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
        .enc_a(enc_a), .enc_b(enc_b), .rate_word(rate_word));

    function automatic int exp_rate(int i);
        real r;
        r = 128.0 * $pow(2.0, i / 12.0);
        return $rtoi(r + 0.5);
    endfunction

    task automatic check(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, expv);
        end
    endtask

    task automatic strobes(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) smp_stb = 1'b1;
            @(negedge clk) smp_stb = 1'b0;
        end
    endtask

    task automatic model_scan(bit a, bit b);
        if (!m_latched && !a) begin
            m_latched = 1'b1;
            if (b) begin if (m_idx > 0) m_idx--; end
            else   begin if (m_idx < 24) m_idx++; end
        end else if (m_latched && a) begin
            m_latched = 1'b0;
        end
    endtask

    // one full scan: settle pins, 64 strobes, check R8 timing and value
    task automatic scan(bit a, bit b, string req);
        int old_v;
        @(negedge clk) begin enc_a = a; enc_b = b; end
        repeat (3) @(negedge clk);
        old_v = exp_rate(m_idx);
        strobes(63);
        @(negedge clk) smp_stb = 1'b1;
        @(negedge clk) smp_stb = 1'b0;
        model_scan(a, b);
        check("R8", int'(rate_word), old_v);
        @(negedge clk);
        check(req, int'(rate_word), exp_rate(m_idx));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", int'(rate_word), 16'h0100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", int'(rate_word), 16'h0100);

        // R2: 63 strobes with A low give no step; the 64th does
        @(negedge clk) begin enc_a = 1'b0; enc_b = 1'b0; end
        repeat (3) @(negedge clk);
        strobes(63);
        repeat (3) @(negedge clk);
        check("R2", int'(rate_word), 16'h0100);
        strobes(1);
        model_scan(1'b0, 1'b0);
        repeat (2) @(negedge clk);
        check("R3", int'(rate_word), 16'h010F);

        // R4: A held low, B toggling: no further steps
        scan(1'b0, 1'b1, "R4");
        scan(1'b0, 1'b0, "R4");
        // R3: rearm with A high gives no step
        scan(1'b1, 1'b1, "R3");

        // R9: A falls in the same cycle as the tick strobe, so that scan misses it
        @(negedge clk) enc_b = 1'b0;
        repeat (3) @(negedge clk);
        strobes(63);
        @(negedge clk) begin smp_stb = 1'b1; enc_a = 1'b0; end
        @(negedge clk) smp_stb = 1'b0;
        repeat (2) @(negedge clk);
        check("R9", int'(rate_word), exp_rate(m_idx));
        scan(1'b0, 1'b0, "R5");

        // R5 R6 R7: sweep up past the top clamp
        for (int t = 0; t < 14; t++) begin
            scan(1'b1, 1'b0, "R4");
            scan(1'b0, 1'b0, "R7");
        end
        check("R6", int'(rate_word), 16'h0200);

        // R5 R6 R7: sweep down past the bottom clamp
        for (int t = 0; t < 28; t++) begin
            scan(1'b1, 1'b1, "R4");
            scan(1'b0, 1'b1, "R5");
        end
        check("R6", int'(rate_word), 16'h0080);

        // back up a few steps from the floor
        for (int t = 0; t < 3; t++) begin
            scan(1'b1, 1'b0, "R3");
            scan(1'b0, 1'b0, "R7");
        end
        check("R7", int'(rate_word), 16'h0098);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule